// File: doc/BRIEF.md
# Retirement Trap-Entry Annotation Unit

This unit sits next to the retirement stage of a RISC-V core and labels every retired instruction for a formal-verification trace port. The core tells it when a synchronous exception, an interrupt (a bus-error NMI counts as an interrupt) or a debug entry is taken, and what the cause is. The unit keeps that event pending until the next instruction retires. That instruction is the first one of the handler, and the unit tags it. Every retirement also carries the current privilege mode.

The retirement stream is valid-only. There is no ready signal, because a trace port cannot stall the core. `ret_valid` qualifies one retirement per cycle, and the annotation appears on `ann_valid` exactly one cycle later. A debug entry alone never marks the trap record. When a debug entry lands on the first instruction of a trap handler, the trap fields stay set and the debug cause is reported alongside them.

Top module: `trap_annot`

## Requirements
- R1: While reset is asserted, and after it is released until the first retirement, every output is zero and nothing is pending.
- R2: `ann_valid` equals `ret_valid` delayed by one cycle. In any cycle where `ann_valid` is 0, `ann_trap`, `ann_dbg` and `ann_mode` are all zero.
- R3: The trap record is 14 bits wide: bit 0 is the handler-entry flag, bit 1 the exception flag, bit 2 the interrupt flag, and bits 13:3 the 11-bit cause. A taken exception is reported as flags 1/1/0 together with its cause.
- R4: A taken interrupt is reported as flags 1/0/1 together with its cause.
- R5: A trap stays pending until the next retirement, is reported on that retirement only, and is cleared afterwards. A trap taken in the same cycle as a retirement applies to the following retirement.
- R6: A newer trap taken before the pending one is reported replaces it. If an exception and an interrupt are taken in the same cycle, the interrupt wins.
- R7: A debug entry without a pending trap leaves the trap record at zero. `ann_dbg` carries its 3-bit code (1 breakpoint instruction, 2 trigger, 3 or 5 external request, 4 single step) on the first retirement only, and is zero on all others.
- R8: A debug entry taken while a trap is pending reports both the trap record and the debug code on the same retirement.
- R9: `ann_mode` reports the `cur_mode` value present in the retiring cycle.
- R10: `ann_halt` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| exc_take | input | 1 | Synchronous exception taken |
| exc_cause | input | 11 | Exception cause |
| irq_take | input | 1 | Interrupt or NMI taken |
| irq_cause | input | 11 | Interrupt cause |
| dbg_take | input | 1 | Debug entry taken |
| dbg_code | input | 3 | Debug entry reason code |
| cur_mode | input | 2 | Current privilege mode |
| ann_valid | output | 1 | Annotation valid |
| ann_trap | output | 14 | Trap record: cause, interrupt, exception, entry |
| ann_dbg | output | 3 | Debug code on the first debug handler instruction |
| ann_mode | output | 2 | Privilege mode of the retired instruction |
| ann_halt | output | 1 | Halt indication, constant 0 |

## Verification
The bench builds the unit with its default widths: an 11-bit cause, a 3-bit debug code and a 2-bit mode. These widths let it drive the all-ones cause 0x7FF, so the top bit of the record is exercised, and try every debug code and every mode value. Directed sequences cover pending traps that span idle cycles, overwrite and priority between traps, a trap taken in the same cycle as a retirement, and debug entry both alone and stacked on a trap.

// File: rtl/trap_annot_pkg.sv
package trap_annot_pkg;
  localparam int REC_ENTRY = 0;
  localparam int REC_EXC   = 1;
  localparam int REC_IRQ   = 2;
  localparam int REC_FLAGS = 3;

  typedef enum logic [1:0] {
    TK_NONE = 2'd0,
    TK_EXC  = 2'd1,
    TK_IRQ  = 2'd2
  } trap_kind_e;
endpackage

// File: rtl/trap_hold.sv
module trap_hold
  import trap_annot_pkg::*;
#(
  parameter int CAUSE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire,
  input  logic               exc_take,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               irq_take,
  input  logic [CAUSE_W-1:0] irq_cause,
  output trap_kind_e         pend_kind,
  output logic [CAUSE_W-1:0] pend_cause
);
  trap_kind_e         kind_q;
  logic [CAUSE_W-1:0] cause_q;

  // a new take wins over the clear caused by a retirement in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= TK_NONE;
      cause_q <= '0;
    end else if (irq_take) begin
      kind_q  <= TK_IRQ;
      cause_q <= irq_cause;
    end else if (exc_take) begin
      kind_q  <= TK_EXC;
      cause_q <= exc_cause;
    end else if (retire) begin
      kind_q  <= TK_NONE;
      cause_q <= '0;
    end
  end

  assign pend_kind  = kind_q;
  assign pend_cause = cause_q;
endmodule

// File: rtl/dbg_hold.sv
module dbg_hold #(
  parameter int DBG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             dbg_take,
  input  logic [DBG_W-1:0] dbg_code,
  output logic [DBG_W-1:0] pend_code
);
  logic [DBG_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        code_q <= '0;
    else if (dbg_take) code_q <= dbg_code;
    else if (retire)   code_q <= '0;
  end

  assign pend_code = code_q;
endmodule

// File: rtl/rec_pack.sv
module rec_pack
  import trap_annot_pkg::*;
#(
  parameter int CAUSE_W = 11,
  localparam int REC_W  = CAUSE_W + REC_FLAGS
) (
  input  trap_kind_e         kind,
  input  logic [CAUSE_W-1:0] cause,
  output logic [REC_W-1:0]   rec
);
  always_comb begin
    rec = '0;
    if (kind != TK_NONE) begin
      rec[REC_ENTRY]                   = 1'b1;
      rec[REC_EXC]                     = (kind == TK_EXC);
      rec[REC_IRQ]                     = (kind == TK_IRQ);
      rec[REC_W-1:REC_FLAGS]           = cause;
    end
  end
endmodule

// File: rtl/trap_annot.sv
module trap_annot
  import trap_annot_pkg::*;
#(
  parameter int CAUSE_W = 11,
  parameter int DBG_W   = 3,
  parameter int MODE_W  = 2,
  localparam int REC_W  = CAUSE_W + REC_FLAGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ret_valid,
  input  logic               exc_take,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               irq_take,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  logic               dbg_take,
  input  logic [DBG_W-1:0]   dbg_code,
  input  logic [MODE_W-1:0]  cur_mode,
  output logic               ann_valid,
  output logic [REC_W-1:0]   ann_trap,
  output logic [DBG_W-1:0]   ann_dbg,
  output logic [MODE_W-1:0]  ann_mode,
  output logic               ann_halt
);
  trap_kind_e         pend_kind;
  logic [CAUSE_W-1:0] pend_cause;
  logic [DBG_W-1:0]   pend_code;
  logic [REC_W-1:0]   rec_now;

  trap_hold #(.CAUSE_W(CAUSE_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .retire(ret_valid),
    .exc_take(exc_take), .exc_cause(exc_cause),
    .irq_take(irq_take), .irq_cause(irq_cause),
    .pend_kind(pend_kind), .pend_cause(pend_cause)
  );

  dbg_hold #(.DBG_W(DBG_W)) u_dbg (
    .clk(clk), .rst_n(rst_n), .retire(ret_valid),
    .dbg_take(dbg_take), .dbg_code(dbg_code), .pend_code(pend_code)
  );

  rec_pack #(.CAUSE_W(CAUSE_W)) u_pack (
    .kind(pend_kind), .cause(pend_cause), .rec(rec_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ann_valid <= 1'b0;
      ann_trap  <= '0;
      ann_dbg   <= '0;
      ann_mode  <= '0;
    end else begin
      ann_valid <= ret_valid;
      ann_trap  <= ret_valid ? rec_now   : '0;
      ann_dbg   <= ret_valid ? pend_code : '0;
      ann_mode  <= ret_valid ? cur_mode  : '0;
    end
  end

  assign ann_halt = 1'b0;
endmodule

// File: rtl/trap_annot_chk.sv
module trap_annot_chk #(
  parameter int CAUSE_W = 11,
  parameter int DBG_W   = 3,
  parameter int MODE_W  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ret_valid,
  input logic [MODE_W-1:0]    cur_mode,
  input logic                 ann_valid,
  input logic [CAUSE_W+2:0]   ann_trap,
  input logic [DBG_W-1:0]     ann_dbg,
  input logic [MODE_W-1:0]    ann_mode,
  input logic                 ann_halt
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ann_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> (!ann_valid && ann_trap == '0 && ann_dbg == '0 && ann_mode == '0)); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ann_trap[1] && ann_trap[2])); // R6
  AST_FLAGS_NEED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ann_trap[1] || ann_trap[2]) |-> ann_trap[0]); // R3
  AST_ENTRY_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    ann_trap[0] |-> $countones(ann_trap[2:1]) == 1); // R4
  AST_MODE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ann_mode == $past(cur_mode)); // R9
  AST_HALT_LOW: assert property (@(posedge clk) ann_halt == 1'b0); // R10
endmodule

bind trap_annot trap_annot_chk #(.CAUSE_W(CAUSE_W), .DBG_W(DBG_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .cur_mode(cur_mode),
  .ann_valid(ann_valid), .ann_trap(ann_trap), .ann_dbg(ann_dbg),
  .ann_mode(ann_mode), .ann_halt(ann_halt)
);

// File: tb/trap_annot_test.sv
module trap_annot_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic        exc_take = 1'b0;
  logic [10:0] exc_cause = '0;
  logic        irq_take = 1'b0;
  logic [10:0] irq_cause = '0;
  logic        dbg_take = 1'b0;
  logic [2:0]  dbg_code = '0;
  logic [1:0]  cur_mode = '0;
  logic        ann_valid;
  logic [13:0] ann_trap;
  logic [2:0]  ann_dbg;
  logic [1:0]  ann_mode;
  logic        ann_halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_annot uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid),
    .exc_take(exc_take), .exc_cause(exc_cause),
    .irq_take(irq_take), .irq_cause(irq_cause),
    .dbg_take(dbg_take), .dbg_code(dbg_code), .cur_mode(cur_mode),
    .ann_valid(ann_valid), .ann_trap(ann_trap), .ann_dbg(ann_dbg),
    .ann_mode(ann_mode), .ann_halt(ann_halt)
  );

  function automatic logic [13:0] exc_rec(input logic [10:0] c);
    return {c, 3'b011};
  endfunction
  function automatic logic [13:0] irq_rec(input logic [10:0] c);
    return {c, 3'b101};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // one cycle: inputs applied at the falling edge, outputs sampled after the rising edge
  task automatic cyc(input bit ret, input bit e, input int ec, input bit i, input int ic,
                     input bit d, input int dc, input int m);
    @(negedge clk);
    ret_valid = ret; exc_take = e; exc_cause = 11'(ec);
    irq_take = i; irq_cause = 11'(ic); dbg_take = d; dbg_code = 3'(dc);
    cur_mode = 2'(m);
    @(posedge clk);
    #1;
    @(negedge clk);
    ret_valid = 0; exc_take = 0; irq_take = 0; dbg_take = 0;
  endtask

  task automatic retire_chk(input string req, input int m, input int rec, input int dc);
    cyc(1, 0, 0, 0, 0, 0, 0, m);
    chk(req, "valid", int'(ann_valid), 1);
    chk(req, "trap", int'(ann_trap), rec);
    chk(req, "dbg", int'(ann_dbg), dc);
  endtask

  task automatic t_reset;
    chk("R1", "valid", int'(ann_valid), 0);
    chk("R1", "trap", int'(ann_trap), 0);
    chk("R1", "dbg", int'(ann_dbg), 0);
    chk("R1", "mode", int'(ann_mode), 0);
    retire_chk("R1", 0, 0, 0);
  endtask

  task automatic t_sync_trap;
    cyc(0, 1, 11'h00B, 0, 0, 0, 0, 3);
    chk("R2", "idle valid", int'(ann_valid), 0);
    chk("R2", "idle mode", int'(ann_mode), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 3);
    retire_chk("R3", 3, int'(exc_rec(11'h00B)), 0);
    retire_chk("R5", 3, 0, 0);
  endtask

  task automatic t_irq;
    cyc(0, 0, 0, 1, 11'h7FF, 0, 0, 0);
    retire_chk("R4", 0, int'(irq_rec(11'h7FF)), 0);
    cyc(0, 0, 0, 1, 11'h00C, 0, 0, 0);
    retire_chk("R4", 0, int'(irq_rec(11'h00C)), 0);
  endtask

  task automatic t_overwrite;
    cyc(0, 1, 2, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 7, 0, 0, 0);
    retire_chk("R6", 0, int'(irq_rec(11'd7)), 0);
    cyc(0, 0, 0, 1, 9, 0, 0, 0);
    cyc(0, 1, 6, 0, 0, 0, 0, 0);
    retire_chk("R6", 0, int'(exc_rec(11'd6)), 0);
    cyc(0, 1, 3, 1, 5, 0, 0, 0);
    retire_chk("R6", 0, int'(irq_rec(11'd5)), 0);
  endtask

  task automatic t_same_cycle;
    cyc(1, 1, 4, 0, 0, 0, 0, 1);
    chk("R5", "same-cycle trap", int'(ann_trap), 0);
    retire_chk("R5", 1, int'(exc_rec(11'd4)), 0);
    retire_chk("R5", 1, 0, 0);
  endtask

  task automatic t_debug_alone;
    for (int c = 1; c <= 5; c++) begin
      cyc(0, 0, 0, 0, 0, 1, c, 3);
      retire_chk("R7", 3, 0, c);
      retire_chk("R7", 3, 0, 0);
    end
  endtask

  task automatic t_debug_on_trap;
    cyc(0, 1, 2, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 4, 0);
    retire_chk("R8", 0, int'(exc_rec(11'd2)), 4);
    cyc(0, 0, 0, 1, 11, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 3, 0);
    retire_chk("R8", 0, int'(irq_rec(11'd11)), 3);
    retire_chk("R8", 0, 0, 0);
  endtask

  task automatic t_mode_halt;
    for (int m = 0; m < 4; m++) begin
      cyc(1, 0, 0, 0, 0, 0, 0, m);
      chk("R9", "mode", int'(ann_mode), m);
      chk("R10", "halt", int'(ann_halt), 0);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 3);
    chk("R2", "mode when idle", int'(ann_mode), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_hold();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset;
    t_sync_trap;
    t_irq;
    t_overwrite;
    t_same_cycle;
    t_debug_alone;
    t_debug_on_trap;
    t_mode_halt;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic t_reset_hold;
    chk("R1", "valid in reset", int'(ann_valid), 0);
    chk("R1", "trap in reset", int'(ann_trap), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule